// File: doc/BRIEF.md
# UART Transmitter with Flow Control

This block is the transmit half of a serial port. The host pushes bytes through a write strobe into a transmit queue. In queue mode the queue holds 16 entries. In single-register mode it holds one byte. A shift stage takes one byte at a time and sends it on a single line as a frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit, and a high stop bit. Each bit lasts 16 pulses of an external 16x rate enable.

Two independent mechanisms can hold back the next character.
- Hardware gating: when automatic clear-to-send gating is enabled and the active-low clear-to-send input is high, no new character starts.
- Software gating: characters arriving from the companion receiver on a valid/data pair are compared against two programmable "stop" codes and two programmable "go" codes.

Either pause takes effect only between characters. A frame that has already started always finishes.

The block raises a transmit interrupt in two cases: when the queue level falls below a programmable trigger level, and when the queue becomes empty. The host clears it by acknowledging, or by writing enough data to bring the level back up to the trigger.

Top module: `uart_tx_flow`

## Requirements
- R1: The serial output idles at 1. A frame is a 0 start bit, 8 data bits sent least significant bit first, a parity bit only when `parityEn`=1, and a 1 stop bit. Each bit lasts 16 cycles in which `tick16`=1. The parity bit is the XOR of the data bits when `parityOdd`=0 (even parity) and the inverse of that XOR when `parityOdd`=1 (odd parity).
- R2: With `fifoEn`=1, up to 16 bytes are queued and sent in the order they were written. `fifoCount` shows the number of queued bytes that have not yet been started.
- R3: A write while the queue is full is dropped. The count and the transmitted data are unaffected.
- R4: With `fifoEn`=0 the queue capacity is one byte, so a second write before that byte starts is dropped.
- R5: While `autoCts`=1 and `ctsN`=1 no new frame starts. While `autoCts`=0, `ctsN` has no effect.
- R6: With `swFlowEn`=1, a received byte (`rxValid`=1) equal to `stopCodeA` or `stopCodeB` pauses transmission. A received byte equal to `goCodeA` or `goCodeB` resumes it.
- R7: A frame in progress when a pause condition appears completes in full. The pause stops only the following frame.
- R8: With `fifoEn`=1, `txIrq` is set when a byte leaves the queue and the new count is below `trigLvl`.
- R9: `txIrq` is set when a byte leaves the queue and the queue becomes empty.
- R10: `txIrq` is 0 after reset. It is cleared by `irqAck`, or by an accepted write that brings the count to at least the threshold (`trigLvl` in queue mode, 1 in single-register mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable |
| fifoEn | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| trigLvl | input | 5 | Interrupt trigger level |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Host write byte |
| irqAck | input | 1 | Interrupt identification read strobe |
| autoCts | input | 1 | Enable clear-to-send gating |
| ctsN | input | 1 | Clear-to-send, active low |
| swFlowEn | input | 1 | Enable stop/go character gating |
| rxValid | input | 1 | Received character valid |
| rxData | input | 8 | Received character |
| stopCodeA | input | 8 | First pause character |
| stopCodeB | input | 8 | Second pause character |
| goCodeA | input | 8 | First resume character |
| goCodeB | input | 8 | Second resume character |
| txd | output | 1 | Serial output |
| txIrq | output | 1 | Transmit interrupt |
| fifoCount | output | 5 | Bytes waiting in the queue |

## Verification
The serialiser is driven with random byte bursts of random length, under random parity settings. A bench-side frame decoder compares each received frame with a bench queue. This separates wrong bit order, wrong parity sense and lost or reordered bytes.

Directed sequences cover the remaining behaviour:
- Overfilling the queue in both capacities shows whether extra writes are dropped.
- Asserting each pause source before a frame and in the middle of a frame distinguishes gating at character boundaries from truncating a frame.
- A wrong stop/go match shows up as an early or missing frame.
- Stepping the level past a trigger of 8, and writes against a trigger of 2, tell the below-trigger set apart from the empty set and from each clear path.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // strobes from control into datapath
  typedef struct packed {
    logic push;  // accept host byte into queue
    logic load;  // move queue head into shifter and start a frame
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OSR    = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick16,
  input  logic                         parityEn,
  input  logic                         parityOdd,
  input  logic [DATA_W-1:0]            wrData,
  input  txStrobe_t                    strobe,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         busy,
  output logic                         txd
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int TICK_W = $clog2(OSR);
  localparam int BIT_W  = $clog2(DATA_W + 3);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] headData, shReg;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitIdx, lastIdx;
  logic              parBit, parEnQ;

  assign headData = mem[rdPtr];
  assign lastIdx  = parEnQ ? BIT_W'(DATA_W + 2) : BIT_W'(DATA_W + 1);

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (strobe.load) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.load);
    end
  end

  // shifter: bitIdx 0 = start, 1..DATA_W = data, then parity (optional), then stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      txd     <= 1'b1;
      tickCnt <= '0;
      bitIdx  <= '0;
      shReg   <= '0;
      parBit  <= 1'b0;
      parEnQ  <= 1'b0;
    end else if (strobe.load) begin
      busy    <= 1'b1;
      txd     <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
      shReg   <= headData;
      parBit  <= (^headData) ^ parityOdd;
      parEnQ  <= parityEn;
    end else if (tick16 && busy) begin
      if (tickCnt == TICK_W'(OSR - 1)) begin
        tickCnt <= '0;
        if (bitIdx == lastIdx) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          bitIdx <= bitIdx + BIT_W'(1);
          if (bitIdx < BIT_W'(DATA_W)) begin
            txd   <= shReg[0];
            shReg <= shReg >> 1;
          end else if (bitIdx == BIT_W'(DATA_W) && parEnQ) begin
            txd <= parBit;
          end else begin
            txd <= 1'b1;
          end
        end
      end else begin
        tickCnt <= tickCnt + TICK_W'(1);
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN) !busy |-> txd);
  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> !txd);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN) count <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick16,
  input  logic                         fifoEn,
  input  logic [$clog2(DEPTH+1)-1:0]   trigLvl,
  input  logic                         wrEn,
  input  logic                         irqAck,
  input  logic                         autoCts,
  input  logic                         ctsN,
  input  logic                         swFlowEn,
  input  logic                         rxValid,
  input  logic [DATA_W-1:0]            rxData,
  input  logic [DATA_W-1:0]            stopCodeA,
  input  logic [DATA_W-1:0]            stopCodeB,
  input  logic [DATA_W-1:0]            goCodeA,
  input  logic [DATA_W-1:0]            goCodeB,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic                         busy,
  output txStrobe_t                    strobe,
  output logic                         txIrq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cap, thr;
  logic [CNT_W:0]   newCount;
  logic             full, stopHit, goHit, swHold, paused;

  assign cap  = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign thr  = fifoEn ? trigLvl : CNT_W'(1);
  assign full = (count >= cap);

  assign stopHit = rxValid && (rxData == stopCodeA || rxData == stopCodeB);
  assign goHit   = rxValid && (rxData == goCodeA || rxData == goCodeB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          swHold <= 1'b0;
    else if (!swFlowEn) swHold <= 1'b0;
    else if (stopHit)   swHold <= 1'b1;
    else if (goHit)     swHold <= 1'b0;
  end

  assign paused      = (autoCts && ctsN) || (swFlowEn && swHold);
  assign strobe.push = wrEn && !full;
  assign strobe.load = tick16 && !busy && (count != '0) && !paused;

  assign newCount = {1'b0, count} + {{CNT_W{1'b0}}, strobe.push} - {{CNT_W{1'b0}}, strobe.load};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq <= 1'b0;
    end else if (strobe.load && (newCount < {1'b0, thr} || newCount == '0)) begin
      txIrq <= 1'b1;
    end else if (irqAck || (strobe.push && newCount >= {1'b0, thr})) begin
      txIrq <= 1'b0;
    end
  end

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !strobe.load) |=> $stable(count));
  // R5
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoCts && ctsN && !busy) |=> !busy);
  // R10
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !strobe.load) |=> !txIrq);
  // R6
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swFlowEn && $past(swFlowEn) && $past(stopHit) && !busy) |=> !busy);
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OSR    = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick16,
  input  logic                        fifoEn,
  input  logic                        parityEn,
  input  logic                        parityOdd,
  input  logic [$clog2(DEPTH+1)-1:0]  trigLvl,
  input  logic                        wrEn,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        irqAck,
  input  logic                        autoCts,
  input  logic                        ctsN,
  input  logic                        swFlowEn,
  input  logic                        rxValid,
  input  logic [DATA_W-1:0]           rxData,
  input  logic [DATA_W-1:0]           stopCodeA,
  input  logic [DATA_W-1:0]           stopCodeB,
  input  logic [DATA_W-1:0]           goCodeA,
  input  logic [DATA_W-1:0]           goCodeB,
  output logic                        txd,
  output logic                        txIrq,
  output logic [$clog2(DEPTH+1)-1:0]  fifoCount
);
  txStrobe_t strobe;
  logic      busy;

  uart_tx_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .fifoEn(fifoEn), .trigLvl(trigLvl),
    .wrEn(wrEn), .irqAck(irqAck), .autoCts(autoCts), .ctsN(ctsN),
    .swFlowEn(swFlowEn), .rxValid(rxValid), .rxData(rxData),
    .stopCodeA(stopCodeA), .stopCodeB(stopCodeB), .goCodeA(goCodeA), .goCodeB(goCodeB),
    .count(fifoCount), .busy(busy), .strobe(strobe), .txIrq(txIrq)
  );

  uart_tx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OSR(OSR)) u_dp (
    .clk(clk), .rstN(rstN), .tick16(tick16), .parityEn(parityEn), .parityOdd(parityOdd),
    .wrData(wrData), .strobe(strobe), .count(fifoCount), .busy(busy), .txd(txd)
  );

  // R5
  cts_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!(autoCts && ctsN)));
endmodule

// File: tb/sim_uart_tx_flow.sv
module sim_uart_tx_flow;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, tick16 = 1'b1;
  logic fifoEn = 1'b1, parityEn = 1'b0, parityOdd = 1'b0;
  logic [4:0] trigLvl = 5'd4;
  logic wrEn = 1'b0, irqAck = 1'b0, autoCts = 1'b0, ctsN = 1'b0, swFlowEn = 1'b0, rxValid = 1'b0;
  logic [7:0] wrData = '0, rxData = '0;
  logic [7:0] stopCodeA = 8'h13, stopCodeB = 8'h93, goCodeA = 8'h11, goCodeB = 8'h91;
  logic txd, txIrq;
  logic [4:0] fifoCount;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_flow u0 (
    .clk(clk), .rstN(rstN), .tick16(tick16), .fifoEn(fifoEn), .parityEn(parityEn),
    .parityOdd(parityOdd), .trigLvl(trigLvl), .wrEn(wrEn), .wrData(wrData), .irqAck(irqAck),
    .autoCts(autoCts), .ctsN(ctsN), .swFlowEn(swFlowEn), .rxValid(rxValid), .rxData(rxData),
    .stopCodeA(stopCodeA), .stopCodeB(stopCodeB), .goCodeA(goCodeA), .goCodeB(goCodeB),
    .txd(txd), .txIrq(txIrq), .fifoCount(fifoCount)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expParity(input logic [7:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk); wrEn = 1'b1; wrData = b;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rxChar(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxData = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic waitLow(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (txd == 1'b0) seen = 1'b1;
    end
  endtask

  task automatic waitCount(input int n);
    for (int i = 0; i < 4000 && fifoCount != 5'(n); i++) @(negedge clk);
  endtask

  // decode one frame independently of the design and compare with the expected byte
  task automatic decodeFrame(input logic [7:0] exp, input string tag);
    bit seen;
    logic [7:0] got;
    logic st, par, stp;
    bit ok;
    waitLow(seen);
    got = '0; par = 1'b0;
    repeat (8) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      got[i] = txd;
    end
    if (parityEn) begin
      repeat (16) @(negedge clk);
      par = txd;
    end
    repeat (16) @(negedge clk);
    stp = txd;
    ok = seen && !st && stp && got == exp && (!parityEn || par == expParity(exp, parityOdd));
    chk(ok, tag, {23'b0, par, got}, {23'b0, expParity(exp, parityOdd), exp});
  endtask

  task automatic quiet(input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
    end
    chk(ok, tag, int'(txd), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] b;
    int n;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state, R1 idle high
    chk(txd == 1'b1, "R1 idle after reset", int'(txd), 1);
    chk(txIrq == 1'b0, "R10 irq after reset", int'(txIrq), 0);
    chk(fifoCount == 0, "R2 count after reset", int'(fifoCount), 0);

    // random bursts: R1 framing/parity, R2 order, R9 empty interrupt
    autoCts = 1'b1;
    for (int it = 0; it < 10; it++) begin
      n = 1 + int'($urandom % 8);
      parityEn = 1'($urandom);
      parityOdd = 1'($urandom);
      ctsN = 1'b1;
      q.delete();
      for (int k = 0; k < n; k++) begin
        b = 8'($urandom);
        q.push_back(b);
        hostWrite(b);
      end
      @(negedge clk);
      chk(fifoCount == 5'(n), "R2 queued count", int'(fifoCount), n);
      ctsN = 1'b0;
      for (int k = 0; k < n; k++) decodeFrame(q[k], "R1 R2 random frame");
      chk(txIrq == 1'b1, "R9 irq on empty", int'(txIrq), 1);
    end

    // R3 overfill 17 writes, R2 order of 16
    parityEn = 1'b0;
    ctsN = 1'b1;
    for (int k = 0; k < 17; k++) hostWrite(8'(8'hA0 + k));
    @(negedge clk);
    chk(fifoCount == 16, "R3 full count", int'(fifoCount), 16);
    ctsN = 1'b0;
    for (int k = 0; k < 16; k++) decodeFrame(8'(8'hA0 + k), "R3 R2 overfill order");
    quiet(300, "R3 dropped byte not sent");

    // R4 single-register mode
    fifoEn = 1'b0;
    ctsN = 1'b1;
    hostWrite(8'h5A); hostWrite(8'hC3); hostWrite(8'h77);
    @(negedge clk);
    chk(fifoCount == 1, "R4 holding capacity", int'(fifoCount), 1);
    ctsN = 1'b0;
    decodeFrame(8'h5A, "R4 holding byte");
    quiet(300, "R4 extra writes dropped");
    fifoEn = 1'b1;

    // R5 CTS ignored when gating disabled
    autoCts = 1'b0; ctsN = 1'b1;
    hostWrite(8'h3C);
    decodeFrame(8'h3C, "R5 cts ignored");

    // R5 R7 CTS raised mid-frame
    autoCts = 1'b1; ctsN = 1'b1;
    hostWrite(8'h96); hostWrite(8'h69);
    quiet(200, "R5 cts holds start");
    fork
      decodeFrame(8'h96, "R7 frame completes under cts");
      begin
        bit s;
        @(negedge clk); ctsN = 1'b0;
        waitLow(s);
        ctsN = 1'b1;
      end
    join
    quiet(300, "R7 next frame held by cts");
    chk(fifoCount == 1, "R5 count while held", int'(fifoCount), 1);
    ctsN = 1'b0;
    decodeFrame(8'h69, "R5 resume after cts");

    // R6 R7 software flow control
    autoCts = 1'b0; swFlowEn = 1'b1;
    rxChar(stopCodeA);
    hostWrite(8'h01); hostWrite(8'h02); hostWrite(8'h03);
    quiet(300, "R6 stop code A pauses");
    chk(fifoCount == 3, "R6 count while paused", int'(fifoCount), 3);
    rxChar(8'h55);
    quiet(200, "R6 other char no resume");
    fork
      decodeFrame(8'h01, "R7 frame completes after stop code");
      begin
        bit s;
        rxChar(goCodeB);
        waitLow(s);
        rxChar(stopCodeB);
      end
    join
    quiet(300, "R6 stop code B pauses");
    chk(fifoCount == 2, "R7 next frame held", int'(fifoCount), 2);
    rxChar(goCodeA);
    decodeFrame(8'h02, "R6 go code A resumes");
    decodeFrame(8'h03, "R6 go code A resumes 2");
    swFlowEn = 1'b0;
    repeat (20) @(negedge clk);

    // R10 clear paths with trigger 2
    autoCts = 1'b1; ctsN = 1'b1; trigLvl = 5'd2;
    chk(txIrq == 1'b1, "R9 irq set before clear test", int'(txIrq), 1);
    hostWrite(8'hE1);
    @(negedge clk);
    chk(txIrq == 1'b1, "R10 write below trigger keeps irq", int'(txIrq), 1);
    hostWrite(8'hE2);
    @(negedge clk);
    chk(txIrq == 1'b0, "R10 write reaching trigger clears", int'(txIrq), 0);

    // R8 crossing below trigger 8
    trigLvl = 5'd8;
    for (int k = 0; k < 8; k++) hostWrite(8'(k));
    @(negedge clk);
    chk(fifoCount == 10 && txIrq == 1'b0, "R8 irq low at 10", int'(txIrq), 0);
    ctsN = 1'b0;
    waitCount(8);
    chk(fifoCount == 8 && txIrq == 1'b0, "R8 irq low at trigger", int'(txIrq), 0);
    waitCount(7);
    chk(fifoCount == 7 && txIrq == 1'b1, "R8 irq set below trigger", int'(txIrq), 1);
    ctsN = 1'b1;
    ack();
    @(negedge clk);
    chk(txIrq == 1'b0, "R10 ack clears", int'(txIrq), 0);
    ctsN = 1'b0;
    waitCount(0);
    @(negedge clk);
    chk(txIrq == 1'b1, "R9 irq at empty after ack", int'(txIrq), 1);
    repeat (200) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule